// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures an external signal with a single saturating counter. It has two modes. In gated frequency mode it counts the rising edges of an input during a window made of timebase ticks. One input is a fast signal that passes through a fixed divide-by-eight prescaler; the other is a slow signal that is counted directly. In period mode it counts reference-clock ticks (nominally 900 kHz) across one or two whole periods of the slow input.

A controller picks the mode and the window length, then raises the enable bit. `busy` stays high while a measurement runs. When the window or period closes, `done` rises. The final count is held until the controller drops enable, which clears the counter. Every input is assumed to be synchronous to `clk`. The reference and timebase inputs are one-cycle tick pulses that come from the system oscillator.

Top module: `freq_period_counter`

## Requirements
- R1: After reset, `count` is 0 and both `busy` and `done` are 0.
- R2: A cycle with `meas_en` low clears `count` to 0 and drops both `busy` and `done` at the next clock edge.
- R3: A measurement starts only on a 0-to-1 transition of `meas_en`: `busy` is 1 in the cycle after the rise, with `count` at 0. Holding `meas_en` high after `done` does not start a new measurement.
- R4: With `sel_hf`=1 (frequency mode, fast input), `count` equals the number of rising edges of `hf_in` inside the window divided by 8, rounded down. The prescaler restarts at 0 for each measurement.
- R5: With `sel_hf`=0 and `sel_freq`=1 (frequency mode, slow input), `count` equals the number of rising edges of `lf_in` inside the window.
- R6: The frequency window runs from the cycle after the start through the cycle of the Nth `gate_tick`. N is LONG_TICKS (default 60, for 60 ms with 1 ms ticks) when `short_gate`=0, and SHORT_TICKS (default 30) when `short_gate`=1. `done` is 1 in the following cycle and never earlier.
- R7: With `sel_hf`=0 and `sel_freq`=0 (period mode), counting opens at the first rising edge of `lf_in` after the start. It closes at the 1st further rising edge (`short_gate`=0) or the 2nd (`short_gate`=1). Every cycle with `ref_tick` high after the opening edge, up to and including the closing edge, adds one.
- R8: `count` saturates at all ones (2^CNT_W-1) and does not wrap.
- R9: After `done`, `count` and `done` hold while `meas_en` stays high. Further input edges and ticks are ignored.
- R10: `sel_hf`, `sel_freq` and `short_gate` are sampled at the start. Changes during a measurement have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | Measurement enable; a rise starts, low clears |
| sel_hf | input | 1 | 1: measure the fast input in frequency mode |
| sel_freq | input | 1 | With sel_hf=0: 1 frequency, 0 period mode |
| short_gate | input | 1 | 1: short window or two periods; 0: long window or one period |
| hf_in | input | 1 | Fast measured signal, synchronous |
| lf_in | input | 1 | Slow measured signal, synchronous |
| ref_tick | input | 1 | Reference-clock tick for period mode |
| gate_tick | input | 1 | Timebase tick that builds the window |
| count | output | CNT_W | Measured count |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Measurement complete, count final |

## Verification
The assertions assume that `hf_in` and `lf_in` are already synchronized to `clk`. They also assume that `gate_tick` and `ref_tick` are single-cycle pulses and that the mode inputs are settled in the cycle that `meas_en` rises. The bench drives every input on the falling clock edge, gives each edge on a measured input a full high cycle and a full low cycle, and issues ticks one at a time. It shortens the window and the counter width through parameters, so the gate timing and saturation corners are reached within a few hundred cycles.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } fpc_state_e;

  typedef enum logic [1:0] {
    MD_HF_FREQ   = 2'd0,
    MD_LF_FREQ   = 2'd1,
    MD_LF_PERIOD = 2'd2
  } fpc_mode_e;

  function automatic fpc_mode_e fpc_decode_mode(input logic hf_sel, input logic freq_sel);
    if (hf_sel)        return MD_HF_FREQ;
    else if (freq_sel) return MD_LF_FREQ;
    else               return MD_LF_PERIOD;
  endfunction

endpackage

// File: rtl/fpc_rise_det.sv
module fpc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/fpc_prescaler.sv
module fpc_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (in_pulse) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign out_pulse = in_pulse & ~clr & (cnt_q == LAST);
endmodule

// File: rtl/fpc_accum.sv
module fpc_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (inc && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAXV && !clr) |=> (cnt_q == MAXV));
endmodule

// File: rtl/fpc_window_ctrl.sv
module fpc_window_ctrl
  import fpc_pkg::*;
#(
  parameter int LONG_TICKS  = 60,
  parameter int SHORT_TICKS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       start,
  input  fpc_mode_e  mode,
  input  logic       short_sel,
  input  logic       gate_tick,
  input  logic       lf_rise,
  output fpc_state_e state
);
  localparam int GW = $clog2(LONG_TICKS + 1);
  localparam logic [GW-1:0] LOAD_LONG  = GW'(LONG_TICKS);
  localparam logic [GW-1:0] LOAD_SHORT = GW'(SHORT_TICKS);

  fpc_state_e    st_q, st_d;
  logic [GW-1:0] gate_q, gate_d;
  logic [1:0]    per_q, per_d;

  always_comb begin
    st_d   = st_q;
    gate_d = gate_q;
    per_d  = per_q;
    if (!enable) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (mode == MD_LF_PERIOD) begin
              st_d = ST_ARM;
            end else begin
              st_d   = ST_RUN;
              gate_d = short_sel ? LOAD_SHORT : LOAD_LONG;
            end
          end
        end
        ST_ARM: begin
          if (lf_rise) begin
            st_d  = ST_RUN;
            per_d = short_sel ? 2'd2 : 2'd1;
          end
        end
        ST_RUN: begin
          if (mode == MD_LF_PERIOD) begin
            if (lf_rise) begin
              if (per_q == 2'd1) st_d = ST_DONE;
              else               per_d = per_q - 1'b1;
            end
          end else if (gate_tick) begin
            if (gate_q == GW'(1)) st_d = ST_DONE;
            else                  gate_d = gate_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gate_q <= '0;
      per_q  <= '0;
    end else begin
      st_q   <= st_d;
      gate_q <= gate_d;
      per_q  <= per_d;
    end
  end

  assign state = st_q;

  // R6
  gate_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && mode != MD_LF_PERIOD && enable && !gate_tick) |=> (st_q != ST_DONE));

  // R7
  period_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM && enable && !lf_rise) |=> (st_q == ST_ARM));
endmodule

// File: rtl/freq_period_counter.sv
module freq_period_counter
  import fpc_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int LONG_TICKS  = 60,
  parameter int SHORT_TICKS = 30,
  parameter int HF_DIV      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_en,
  input  logic             sel_hf,
  input  logic             sel_freq,
  input  logic             short_gate,
  input  logic             hf_in,
  input  logic             lf_in,
  input  logic             ref_tick,
  input  logic             gate_tick,
  output logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             done
);
  logic       en_q;
  logic       start;
  fpc_mode_e  mode_q, mode_d, mode_now;
  logic       short_q, short_d, short_now;
  logic       hf_rise, lf_rise, hf_div_pulse;
  logic       running, inc, clr;
  fpc_state_e state;

  assign start     = meas_en & ~en_q;
  assign mode_now  = start ? fpc_decode_mode(sel_hf, sel_freq) : mode_q;
  assign short_now = start ? short_gate : short_q;
  assign mode_d    = mode_now;
  assign short_d   = short_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= MD_HF_FREQ;
      short_q <= 1'b0;
    end else begin
      en_q    <= meas_en;
      mode_q  <= mode_d;
      short_q <= short_d;
    end
  end

  fpc_rise_det u_hf_rise (.clk(clk), .rst_n(rst_n), .sig(hf_in), .rise(hf_rise));
  fpc_rise_det u_lf_rise (.clk(clk), .rst_n(rst_n), .sig(lf_in), .rise(lf_rise));

  assign running = (state == ST_RUN);

  fpc_prescaler #(.DIV(HF_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n),
    .clr(~(running && mode_q == MD_HF_FREQ)),
    .in_pulse(hf_rise),
    .out_pulse(hf_div_pulse)
  );

  fpc_window_ctrl #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_win (
    .clk(clk), .rst_n(rst_n),
    .enable(meas_en), .start(start),
    .mode(mode_now), .short_sel(short_now),
    .gate_tick(gate_tick), .lf_rise(lf_rise),
    .state(state)
  );

  always_comb begin
    inc = 1'b0;
    if (running) begin
      case (mode_q)
        MD_HF_FREQ:   inc = hf_div_pulse;
        MD_LF_FREQ:   inc = lf_rise;
        default:      inc = ref_tick;
      endcase
    end
  end

  assign clr = start | ~meas_en;

  fpc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cnt(count)
  );

  assign busy = (state == ST_ARM) || (state == ST_RUN);
  assign done = (state == ST_DONE);

  // R2
  clr_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (count == '0 && !busy && !done));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && !en_q) |=> (busy && count == '0));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && meas_en) |=> (done && $stable(count)));
endmodule

// File: tb/freq_period_counter_tb.sv
`timescale 1ns/1ps
module freq_period_counter_tb;
  localparam int CW = 6;
  localparam int LT = 4;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst_n, meas_en, sel_hf, sel_freq, short_gate;
  logic hf_in, lf_in, ref_tick, gate_tick;
  logic [CW-1:0] count;
  logic busy, done;

  int checks = 0;
  int errors = 0;
  int     exp_q[$];
  string  req_q[$];

  always #2.5 clk = ~clk;

  freq_period_counter #(.CNT_W(CW), .LONG_TICKS(LT), .SHORT_TICKS(ST), .HF_DIV(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .sel_hf(sel_hf), .sel_freq(sel_freq),
    .short_gate(short_gate), .hf_in(hf_in), .lf_in(lf_in), .ref_tick(ref_tick),
    .gate_tick(gate_tick), .count(count), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compare final count when done rises
  initial begin
    logic done_q;
    done_q = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !done_q) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected done", 1, 0);
        end else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(int'(count) == e, r, int'(count), e);
        end
      end
      done_q = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  task automatic pulse_lf();
    lf_in = 1'b1; @(negedge clk); lf_in = 1'b0; @(negedge clk);
  endtask
  task automatic pulse_hf();
    hf_in = 1'b1; @(negedge clk); hf_in = 1'b0; @(negedge clk);
  endtask
  task automatic tick();
    gate_tick = 1'b1; @(negedge clk); gate_tick = 1'b0;
  endtask
  task automatic lf_gap(input int p);
    lf_in = 1'b1; @(negedge clk); lf_in = 1'b0;
    repeat (p - 1) @(negedge clk);
  endtask
  task automatic stop_meas();
    meas_en = 1'b0; ref_tick = 1'b0; @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; meas_en = 1'b0; sel_hf = 1'b0; sel_freq = 1'b0; short_gate = 1'b0;
    hf_in = 1'b0; lf_in = 1'b0; ref_tick = 1'b0; gate_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(count == 0, "R1 count", int'(count), 0);
    check(!busy, "R1 busy", int'(busy), 0);
    check(!done, "R1 done", int'(done), 0);

    // slow input, long window
    sel_hf = 1'b0; sel_freq = 1'b1; short_gate = 1'b0;
    push_exp(5, "R5 lf freq count");
    meas_en = 1'b1; @(negedge clk);
    check(busy, "R3 busy after rise", int'(busy), 1);
    repeat (5) pulse_lf();
    repeat (LT - 1) tick();
    check(!done, "R6 long gate not early", int'(done), 0);
    tick();
    check(done, "R6 long gate done", int'(done), 1);
    repeat (2) pulse_lf();
    tick();
    check(count == 5, "R9 count held", int'(count), 5);
    check(done && !busy, "R3 no restart while high", int'(busy), 0);
    stop_meas();
    check(count == 0, "R2 count cleared", int'(count), 0);
    check(!done && !busy, "R2 idle", int'(done), 0);

    // fast input, short window, prescaled
    sel_hf = 1'b1; short_gate = 1'b1;
    push_exp(2, "R4 hf prescaled count");
    meas_en = 1'b1; @(negedge clk);
    repeat (17) pulse_hf();
    tick();
    check(!done, "R6 short gate not early", int'(done), 0);
    tick();
    check(done, "R6 short gate done", int'(done), 1);
    stop_meas();

    // period mode, one period
    sel_hf = 1'b0; sel_freq = 1'b0; short_gate = 1'b0; ref_tick = 1'b1;
    push_exp(9, "R7 one period");
    meas_en = 1'b1; @(negedge clk);
    check(busy && count == 0, "R7 armed no count", int'(count), 0);
    repeat (2) lf_gap(9);
    check(done, "R7 one period done", int'(done), 1);
    stop_meas();

    // period mode, two periods
    short_gate = 1'b1; ref_tick = 1'b1;
    push_exp(14, "R7 two periods");
    meas_en = 1'b1; @(negedge clk);
    repeat (3) lf_gap(7);
    stop_meas();

    // saturation
    short_gate = 1'b0; ref_tick = 1'b1;
    push_exp(63, "R8 saturation");
    meas_en = 1'b1; @(negedge clk);
    repeat (2) lf_gap(70);
    stop_meas();

    // mode bits sampled at start only
    sel_hf = 1'b0; sel_freq = 1'b1; short_gate = 1'b0;
    push_exp(3, "R10 mode latched");
    meas_en = 1'b1; @(negedge clk);
    sel_hf = 1'b1; sel_freq = 1'b0; short_gate = 1'b1;
    repeat (3) pulse_lf();
    repeat (16) pulse_hf();
    repeat (LT - 1) tick();
    check(!done, "R10 long gate kept", int'(done), 0);
    tick();
    stop_meas();

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule